// File: doc/BRIEF.md
# Windowed Speed Measurement Timer

This block turns a stream of already-decoded encoder count pulses into a speed figure. A time-base counter runs from zero up to a programmable period value, wraps to zero and flips a gate signal on each wrap. That gate is wired internally as the trigger of a capture counter. The capture counter accumulates count pulses. Each time the gate goes high, the accumulated total moves into a capture register and the counter restarts. As a result, every window of two time-base periods produces one pulse count.

A third counter tallies index pulses (one per revolution) at all times, whether or not speed measurement is running. Software drives the block through a small write/read register port. It sets the period, enables speed mode and quadrature mode, and starts the measurement with a start command while the clock enable is on. A capture-valid flag tells software that a fresh count is waiting, and the flag drops when the capture register is read.

Top module: `speed_window_timer`

## Requirements
- R1: Measurement is active only while speed-enable (CTRL bit 0), quadrature-enable (CTRL bit 1) and the running flag are all 1. While measurement is inactive, the gate output is 0, the time-base and capture counters are held at zero, and no capture takes place.
- R2: A write to CTRL (address 0) with clock-enable (bit 2) and start (bit 3) both 1 sets the running flag. A CTRL write with bit 2 at 0 clears it. A write with bit 2 at 1 and bit 3 at 0 leaves it unchanged. Reading CTRL returns bits 0..2 as written, bit 3 as 0, and the running flag in bit 4.
- R3: While measurement is active with a nonzero period P (PERIOD, address 1), the time-base counter steps by one each cycle. When the counter is greater than or equal to P, it returns to zero and the gate toggles. With P fixed, the gate therefore toggles every P+1 cycles.
- R4: On the clock edge where the gate goes from 0 to 1, the capture register (address 2) loads the pulses counted since the previous load or since the start. On that same edge the capture counter restarts: it becomes 1 if a count pulse is present in that cycle, and 0 otherwise.
- R5: The capture counter saturates at its all-ones value and does not wrap.
- R6: The capture-valid output goes to 1 on every load. It clears on a cycle where rd_en is 1 with rd_addr 2 and no load occurs. When a load and a read fall in the same cycle, the load takes priority.
- R7: The revolution counter (address 3) increments on every cycle with index_pulse at 1, whatever the mode, and wraps modulo 2^REV_W.
- R8: With P equal to 0 while measurement is active, the time-base counter stays at zero, the gate keeps its value, and no capture occurs.
- R9: After reset, all registers, counters, the gate and capture-valid are 0.
- R10: rd_data is a combinational function of rd_addr and the current register state, zero-extended to DATA_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 CTRL, 1 PERIOD) |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe (clears capture-valid when reading address 2) |
| rd_addr | input | 2 | Read address |
| rd_data | output | DATA_W | Read data |
| count_pulse | input | 1 | Decoded encoder count pulse, one per cycle at most |
| index_pulse | input | 1 | Revolution index pulse |
| gate_o | output | 1 | Time-base gate, also the internal capture trigger |
| cap_valid_o | output | 1 | A new capture is waiting to be read |

## Verification
All state updates on the clock edge that samples the stimulus. This applies to writes, pulses, wraps, captures and the valid flag. gate_o, cap_valid_o and every register value are therefore due one edge after the cycle that caused them, while rd_data follows rd_addr in the same cycle. The bench drives inputs and compares outputs at the falling edge. A behavioural model is updated on the rising edge from the same inputs, so each comparison sees the state after exactly one edge. It uses the rd_addr that is still applied.

// File: rtl/swt_pkg.sv
package swt_pkg;
    typedef enum logic [1:0] {
        ADDR_CTRL    = 2'd0,
        ADDR_PERIOD  = 2'd1,
        ADDR_CAPTURE = 2'd2,
        ADDR_REVS    = 2'd3
    } swt_addr_e;

    localparam int CTRL_SPEED = 0;
    localparam int CTRL_QUAD  = 1;
    localparam int CTRL_CLKEN = 2;
    localparam int CTRL_START = 3;
    localparam int CTRL_RUN   = 4;
endpackage

// File: rtl/swt_timebase.sv
module swt_timebase #(
    parameter int TB_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [TB_W-1:0] period,
    output logic            gate,
    output logic            rise,
    output logic [TB_W-1:0] cnt
);
    typedef struct packed {
        logic [TB_W-1:0] cnt;
        logic            gate;
    } tb_state_t;

    tb_state_t st_d, st_q;
    logic      wrap;

    always_comb begin
        st_d = st_q;
        wrap = en && (period != '0) && (st_q.cnt >= period);
        rise = wrap && !st_q.gate;
        if (!en) begin
            st_d = '0;
        end else if (period == '0) begin
            st_d.cnt = '0;
        end else if (wrap) begin
            st_d.cnt  = '0;
            st_d.gate = ~st_q.gate;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gate = st_q.gate;
    assign cnt  = st_q.cnt;
endmodule

// File: rtl/swt_capture.sv
module swt_capture #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             load,
    input  logic             pulse,
    input  logic             rd_clr,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cap,
    output logic             valid
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cap;
        logic             valid;
    } cap_state_t;

    cap_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d.cnt = '0;
        end else if (load) begin
            st_d.cap = st_q.cnt;
            st_d.cnt = {{(CNT_W-1){1'b0}}, pulse};
        end else if (pulse && (st_q.cnt != CNT_MAX)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (en && load)  st_d.valid = 1'b1;
        else if (rd_clr) st_d.valid = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt   = st_q.cnt;
    assign cap   = st_q.cap;
    assign valid = st_q.valid;
endmodule

// File: rtl/swt_revcount.sv
module swt_revcount #(
    parameter int REV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             index,
    output logic [REV_W-1:0] cnt
);
    logic [REV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (index) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/speed_window_timer.sv
module speed_window_timer
    import swt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int TB_W   = 16,
    parameter int CNT_W  = 16,
    parameter int REV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              count_pulse,
    input  logic              index_pulse,
    output logic              gate_o,
    output logic              cap_valid_o
);
    typedef struct packed {
        logic            speed_en;
        logic            quad_en;
        logic            clk_en;
        logic            run;
        logic [TB_W-1:0] period;
    } regs_t;

    regs_t            rg_d, rg_q;
    logic             active;
    logic             cap_rise;
    logic             rd_clr;
    logic [TB_W-1:0]  tb_cnt;
    logic [TB_W-1:0]  period_w;
    logic [CNT_W-1:0] cap_cnt;
    logic [CNT_W-1:0] cap_val;
    logic [REV_W-1:0] rev_cnt;
    logic             unused_wdata;

    assign unused_wdata = ^wr_data[DATA_W-1:TB_W];

    always_comb begin
        rg_d = rg_q;
        if (wr_en) begin
            case (swt_addr_e'(wr_addr))
                ADDR_CTRL: begin
                    rg_d.speed_en = wr_data[CTRL_SPEED];
                    rg_d.quad_en  = wr_data[CTRL_QUAD];
                    rg_d.clk_en   = wr_data[CTRL_CLKEN];
                    if (wr_data[CTRL_CLKEN] && wr_data[CTRL_START]) rg_d.run = 1'b1;
                    else if (!wr_data[CTRL_CLKEN])                  rg_d.run = 1'b0;
                end
                ADDR_PERIOD: rg_d.period = wr_data[TB_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    assign active   = rg_q.run && rg_q.speed_en && rg_q.quad_en;
    assign period_w = rg_q.period;
    assign rd_clr   = rd_en && (swt_addr_e'(rd_addr) == ADDR_CAPTURE);

    swt_timebase #(.TB_W(TB_W)) u_tb (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (active),
        .period (period_w),
        .gate   (gate_o),
        .rise   (cap_rise),
        .cnt    (tb_cnt)
    );

    swt_capture #(.CNT_W(CNT_W)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (active),
        .load   (cap_rise),
        .pulse  (count_pulse),
        .rd_clr (rd_clr),
        .cnt    (cap_cnt),
        .cap    (cap_val),
        .valid  (cap_valid_o)
    );

    swt_revcount #(.REV_W(REV_W)) u_rev (
        .clk   (clk),
        .rst_n (rst_n),
        .index (index_pulse),
        .cnt   (rev_cnt)
    );

    always_comb begin
        rd_data = '0;
        case (swt_addr_e'(rd_addr))
            ADDR_CTRL: begin
                rd_data[CTRL_SPEED] = rg_q.speed_en;
                rd_data[CTRL_QUAD]  = rg_q.quad_en;
                rd_data[CTRL_CLKEN] = rg_q.clk_en;
                rd_data[CTRL_RUN]   = rg_q.run;
            end
            ADDR_PERIOD:  rd_data[TB_W-1:0]  = rg_q.period;
            ADDR_CAPTURE: rd_data[CNT_W-1:0] = cap_val;
            ADDR_REVS:    rd_data[REV_W-1:0] = rev_cnt;
            default: ;
        endcase
    end
endmodule

// File: rtl/swt_checker.sv
module swt_checker #(
    parameter int TB_W  = 16,
    parameter int CNT_W = 16,
    parameter int REV_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             active,
    input logic [TB_W-1:0]  period,
    input logic [TB_W-1:0]  tb_cnt,
    input logic             gate,
    input logic             rise,
    input logic [CNT_W-1:0] cap_cnt,
    input logic             cap_valid,
    input logic             index_pulse,
    input logic [REV_W-1:0] rev_cnt
);
    assert_gate_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !gate);

    assert_gate_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (active && period != '0 && tb_cnt < period) |=> $stable(gate));

    assert_capture_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> (cap_cnt <= 1));

    assert_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !rise && cap_cnt == {CNT_W{1'b1}}) |=> (cap_cnt == {CNT_W{1'b1}}));

    assert_valid_on_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> cap_valid);

    assert_rev_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        index_pulse |=> (rev_cnt == $past(rev_cnt) + 1'b1));

    assert_rev_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !index_pulse |=> $stable(rev_cnt));

    assert_zero_period_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && period == '0) |=> ($stable(gate) && tb_cnt == '0));
endmodule

bind speed_window_timer swt_checker #(
    .TB_W  (TB_W),
    .CNT_W (CNT_W),
    .REV_W (REV_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .active      (active),
    .period      (period_w),
    .tb_cnt      (tb_cnt),
    .gate        (gate_o),
    .rise        (cap_rise),
    .cap_cnt     (cap_cnt),
    .cap_valid   (cap_valid_o),
    .index_pulse (index_pulse),
    .rev_cnt     (rev_cnt)
);

// File: tb/speed_window_timer_tb.sv
`timescale 1ns/1ps
module speed_window_timer_tb;
    localparam int DATA_W = 32;
    localparam int TB_W   = 16;
    localparam int CNT_W  = 8;
    localparam int REV_W  = 8;
    localparam int CMAX   = (1 << CNT_W) - 1;
    localparam int RMASK  = (1 << REV_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [1:0]        wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              rd_en = 1'b0;
    logic [1:0]        rd_addr = 2'd2;
    logic [DATA_W-1:0] rd_data;
    logic              count_pulse = 1'b0;
    logic              index_pulse = 1'b0;
    logic              gate_o;
    logic              cap_valid_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    speed_window_timer #(.DATA_W(DATA_W), .TB_W(TB_W), .CNT_W(CNT_W), .REV_W(REV_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .count_pulse(count_pulse), .index_pulse(index_pulse),
        .gate_o(gate_o), .cap_valid_o(cap_valid_o)
    );

    // behavioural reference model
    int m_sen, m_qen, m_clken, m_run, m_per, m_tb, m_gate, m_cc, m_cap, m_valid, m_rev;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_sen <= 0; m_qen <= 0; m_clken <= 0; m_run <= 0; m_per <= 0;
            m_tb <= 0; m_gate <= 0; m_cc <= 0; m_cap <= 0; m_valid <= 0; m_rev <= 0;
        end else begin
            int act, wrap, trig;
            act  = (m_run != 0 && m_sen != 0 && m_qen != 0) ? 1 : 0;
            wrap = (act != 0 && m_per != 0 && m_tb >= m_per) ? 1 : 0;
            trig = (wrap != 0 && m_gate == 0) ? 1 : 0;
            if (act == 0) begin
                m_tb <= 0; m_gate <= 0;
            end else if (m_per == 0) begin
                m_tb <= 0;
            end else if (wrap != 0) begin
                m_tb <= 0; m_gate <= 1 - m_gate;
            end else begin
                m_tb <= m_tb + 1;
            end
            if (act == 0) m_cc <= 0;
            else if (trig != 0) begin
                m_cap <= m_cc; m_cc <= count_pulse ? 1 : 0;
            end else if (count_pulse && m_cc != CMAX) m_cc <= m_cc + 1;
            if (trig != 0) m_valid <= 1;
            else if (rd_en && rd_addr == 2'd2) m_valid <= 0;
            if (index_pulse) m_rev <= (m_rev + 1) & RMASK;
            if (wr_en && wr_addr == 2'd0) begin
                m_sen <= wr_data[0]; m_qen <= wr_data[1]; m_clken <= wr_data[2];
                if (wr_data[2] && wr_data[3]) m_run <= 1;
                else if (!wr_data[2]) m_run <= 0;
            end
            if (wr_en && wr_addr == 2'd1) m_per <= int'(wr_data[TB_W-1:0]);
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
        end
    endtask

    task automatic compare_all();
        longint exp_rd;
        string  rtag;
        string  gtag;
        case (rd_addr)
            2'd0: begin exp_rd = m_sen + 2*m_qen + 4*m_clken + 16*m_run; rtag = "R2 ctrl read"; end
            2'd1: begin exp_rd = m_per; rtag = "R10 period read"; end
            2'd2: begin exp_rd = m_cap; rtag = (m_cap == CMAX) ? "R5 capture read" : "R4 capture read"; end
            default: begin exp_rd = m_rev; rtag = "R7 revolution read"; end
        endcase
        if (!(m_run != 0 && m_sen != 0 && m_qen != 0)) gtag = "R1 gate";
        else if (m_per == 0) gtag = "R8 gate";
        else gtag = "R3 gate";
        chk(gtag, gate_o, m_gate);
        chk("R6 capture valid", cap_valid_o, m_valid);
        chk(rtag, rd_data, exp_rd);
    endtask

    task automatic cyc(input logic we, input logic [1:0] wa, input logic [31:0] wd,
                       input logic re, input logic [1:0] ra, input logic cp, input logic ix);
        wr_en = we; wr_addr = wa; wr_data = wd;
        rd_en = re; rd_addr = ra; count_pulse = cp; index_pulse = ix;
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        cyc(1'b1, a, d, 1'b0, 2'd2, 1'b0, 1'b0);
    endtask

    // pmode: 0 none, 1 every cycle, 2 random, 3 every third cycle; ixn: index 1 in ixn
    task automatic run(input int n, input int pmode, input int ixn);
        for (int i = 0; i < n; i++) begin
            logic cp;
            case (pmode)
                1: cp = 1'b1;
                2: cp = ($urandom % 2) == 0;
                3: cp = (i % 3) == 0;
                default: cp = 1'b0;
            endcase
            cyc(1'b0, 2'd0, 32'd0, ($urandom % 4) == 0, 2'($urandom % 4), cp,
                (ixn > 0) ? (($urandom % ixn) == 0) : 1'b0);
        end
    endtask

    initial begin
        logic g0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        chk("R9 gate after reset", gate_o, 0);
        chk("R9 valid after reset", cap_valid_o, 0);
        chk("R9 capture after reset", rd_data, 0);

        // R1: modes set but not started
        wr(2'd1, 32'd4);
        wr(2'd0, 32'h3);
        run(40, 1, 8);
        chk("R1 gate idle before start", gate_o, 0);

        // R2: start
        wr(2'd0, 32'hF);
        cyc(1'b0, 2'd0, 32'd0, 1'b0, 2'd0, 1'b0, 1'b0);
        chk("R2 running flag set", rd_data[4], 1);
        run(200, 2, 8);
        run(60, 3, 8);

        // R3: longer period, then shrink below current count
        wr(2'd1, 32'd20);
        run(50, 2, 8);
        wr(2'd1, 32'd3);
        run(80, 1, 8);

        // R8: zero period holds gate
        wr(2'd1, 32'd0);
        run(1, 1, 0);
        g0 = gate_o;
        run(60, 1, 8);
        chk("R8 gate held with zero period", gate_o, g0);

        // R1: quadrature enable dropped
        wr(2'd1, 32'd5);
        wr(2'd0, 32'hD);
        run(30, 1, 8);
        chk("R1 gate idle without quadrature enable", gate_o, 0);

        // R5: saturation over a long window
        wr(2'd1, 32'd300);
        wr(2'd0, 32'hF);
        run(1300, 1, 8);
        cyc(1'b0, 2'd0, 32'd0, 1'b0, 2'd2, 1'b1, 1'b0);
        chk("R5 saturated capture", rd_data, CMAX);

        // R2: stop, then clock-enable without start
        wr(2'd0, 32'h3);
        run(20, 1, 8);
        wr(2'd0, 32'h7);
        run(20, 1, 8);
        cyc(1'b0, 2'd0, 32'd0, 1'b0, 2'd0, 1'b0, 1'b0);
        chk("R2 no start without start bit", rd_data[4], 0);
        chk("R1 gate idle while stopped", gate_o, 0);

        // R7: burst of index pulses forcing wrap
        for (int i = 0; i < 300; i++) cyc(1'b0, 2'd0, 32'd0, 1'b0, 2'd3, 1'b0, 1'b1);
        chk("R7 revolution count wrapped", rd_data, m_rev);

        // R6: continuous reads during running captures
        wr(2'd1, 32'd2);
        wr(2'd0, 32'hF);
        for (int i = 0; i < 60; i++) cyc(1'b0, 2'd0, 32'd0, 1'b1, 2'd2, 1'b1, 1'b0);
        run(100, 2, 4);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (R1..R10 sequence): actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule